// File: doc/BRIEF.md
# SD Command Issue and Response Engine

This block drives one SD/MMC command onto the card's CMD line and collects the card's answer. Software loads a 32-bit argument, then writes a control word that carries the command index and the response options. The engine forms a 48-bit command token and appends a CRC7. It shifts the token out one bit per SD clock. If a response is requested, it waits for the card's start bit, receives a 48-bit or 136-bit reply, checks its CRC7 and raises a single completion flag.

The block runs on the SD clock. Clock generation, the data lines and the bus register decode sit outside it. A self-clearing reset bit in the control word aborts whatever is in flight and clears all captured results.

Top module: `sd_cmd_engine`

## Requirements
- R1: A start write (control bit 9 set, bit 10 clear) in idle sends 48 bits, most significant first: 0, 1, the index from control bits 5:0, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, initial value 0) over the preceding 40 bits, then 1.
- R2: `cmd_oe` is high for exactly the 48 token bit times and low before and after them.
- R3: When control bit 6 (response wanted) is clear, the status is 7'h40 (only bit 6, command sent) once the end bit has gone out.
- R4: With bit 6 set and bit 7 clear, a 48-bit reply is taken. `resp0` holds its 32 payload bits and `resp_idx` holds the received 6-bit index in bits 5:0 and the command's control bit 8 (application flag) in bit 6. A matching CRC gives status 7'h10 (bit 4).
- R5: With bits 6 and 7 set, a 136-bit reply is taken. The 127 bits after the 8-bit header go to `resp0`..`resp3`, most significant word in `resp0`, with bit 0 of `resp3` zero. The CRC covers only the 120 bits after the header.
- R6: A CRC mismatch in either reply length gives status 7'h01 (bit 0).
- R7: After the end bit, the engine samples the line for up to TIMEOUT (64) SD clocks. A start bit on the 64th sample is accepted. Without one, the status is 7'h04 (bit 2).
- R8: Writing control bit 10 aborts any activity. `rst_busy` then reads 1 for RST_CYCLES clocks and clears by itself. Status, the response words and `resp_idx` return to zero.
- R9: A start write while a command is in flight is ignored, and the token being sent is not disturbed.
- R10: Status clears when a command starts, and at most one status bit is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD clock; one CMD bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_wr | input | 1 | Load command argument |
| arg_wdata | input | 32 | Argument value |
| ctl_wr | input | 1 | Write control word |
| ctl_wdata | input | 11 | Control word: index, response, long, app, start, reset |
| cmd_i | input | 1 | CMD line as seen from the card |
| cmd_o | output | 1 | CMD line value driven by the engine |
| cmd_oe | output | 1 | Output enable for CMD |
| busy | output | 1 | Engine not idle |
| rst_busy | output | 1 | Reset bit readback |
| status | output | 7 | Completion flags: bit 0 CRC fail, 2 timeout, 4 CRC ok, 6 sent |
| resp0 | output | 32 | Response word 0 (most significant) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 (least significant) |
| resp_idx | output | 7 | Received index and application flag |

## Verification
The hardest condition to reach from the ports is a start request that arrives in the middle of a token. Stimulus reaches it by issuing a second start write with a different index at the tenth transmitted bit. The captured token must still match the first command. The timeout boundary is also hard to hit, since a start bit one cycle late must flip the result. The bench therefore places the reply start bit at 63 idle samples, where it must be accepted, and then withholds the reply entirely. Every index from 0 to 63 is swept through the transmit path, with token CRCs computed arithmetically in the bench.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TIMEOUT    = 64,
  parameter int RST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arg_wr,
  input  logic [31:0] arg_wdata,
  input  logic        ctl_wr,
  input  logic [10:0] ctl_wdata,
  input  logic        cmd_i,
  output logic        cmd_o,
  output logic        cmd_oe,
  output logic        busy,
  output logic        rst_busy,
  output logic [6:0]  status,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic [6:0]  resp_idx
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(RST_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_RST} state_t;
  state_t state;

  logic [31:0]  arg_q;
  logic [47:0]  tx_sh;
  logic [7:0]   cnt;
  logic [TW-1:0] tmr;
  logic [RW-1:0] rcnt;
  logic         need_q, long_q, app_q;
  logic [6:0]   crc_c, crc_r;
  logic [5:0]   hdr;
  logic [126:0] dsh;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    crc_step = {c[5:0], 1'b0} ^ ((b ^ c[6]) ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc40(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) c = crc_step(c, d[i]);
    return c;
  endfunction

  wire        start_req = ctl_wr && ctl_wdata[9] && !ctl_wdata[10];
  wire        rst_req   = ctl_wr && ctl_wdata[10];
  wire [39:0] head      = {2'b01, ctl_wdata[5:0], arg_q};
  wire [7:0]  last_b    = long_q ? 8'd134 : 8'd46;
  wire [7:0]  cov_lo    = long_q ? 8'd7   : 8'd0;
  wire [7:0]  cov_hi    = long_q ? 8'd126 : 8'd38;

  assign cmd_oe   = (state == S_TX);
  assign cmd_o    = cmd_oe ? tx_sh[47] : 1'b1;
  assign busy     = (state != S_IDLE);
  assign rst_busy = (state == S_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; arg_q <= '0; tx_sh <= '0; cnt <= '0; tmr <= '0; rcnt <= '0;
      need_q <= 1'b0; long_q <= 1'b0; app_q <= 1'b0; crc_c <= '0; crc_r <= '0;
      hdr <= '0; dsh <= '0; status <= '0;
      resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0; resp_idx <= '0;
    end else begin
      if (arg_wr) arg_q <= arg_wdata;
      if (rst_req) begin
        state <= S_RST; rcnt <= RW'(RST_CYCLES - 1); status <= '0;
        resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0; resp_idx <= '0;
      end else begin
        case (state)
          S_IDLE: if (start_req) begin
            state  <= S_TX;
            tx_sh  <= {head, crc40(head), 1'b1};
            cnt    <= '0;
            need_q <= ctl_wdata[6]; long_q <= ctl_wdata[7]; app_q <= ctl_wdata[8];
            status <= '0;
          end
          S_TX: begin
            tx_sh <= {tx_sh[46:0], 1'b0};
            cnt   <= cnt + 8'd1;
            if (cnt == 8'd47) begin
              tmr <= '0;
              if (need_q) state <= S_WAIT;
              else begin state <= S_IDLE; status <= 7'h40; end
            end
          end
          S_WAIT: begin
            if (!cmd_i) begin
              state <= S_RX; cnt <= '0; crc_c <= '0; dsh <= '0;
            end else if (tmr == TW'(TIMEOUT - 1)) begin
              state <= S_IDLE; status <= 7'h04;
            end else tmr <= tmr + 1'b1;
          end
          S_RX: begin
            cnt <= cnt + 8'd1;
            if (cnt >= 8'd1 && cnt <= 8'd6) hdr <= {hdr[4:0], cmd_i};
            if (cnt >= 8'd7 && cnt < last_b) dsh <= {dsh[125:0], cmd_i};
            if (cnt >= cov_lo && cnt <= cov_hi) crc_c <= crc_step(crc_c, cmd_i);
            else if (cnt < last_b) crc_r <= {crc_r[5:0], cmd_i};
            if (cnt == last_b) begin
              state    <= S_IDLE;
              status   <= (crc_c == crc_r) ? 7'h10 : 7'h01;
              resp_idx <= {app_q, hdr};
              if (long_q) begin
                resp0 <= dsh[126:95]; resp1 <= dsh[94:63];
                resp2 <= dsh[62:31];  resp3 <= {dsh[30:0], 1'b0};
              end else resp0 <= dsh[38:7];
            end
          end
          S_RST: if (rcnt == '0) state <= S_IDLE; else rcnt <= rcnt - 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_oe_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> $past(ctl_wr && ctl_wdata[9] && !ctl_wdata[10]));
  a_r8_reset_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_busy) |-> $past(ctl_wr && ctl_wdata[10]));
  a_r10_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status));
  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctl_wr) |=> $stable(status));
endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 8;

  logic clk = 0, rst_n = 0;
  logic arg_wr = 0, ctl_wr = 0, cmd_i = 1;
  logic [31:0] arg_wdata = '0;
  logic [10:0] ctl_wdata = '0;
  logic cmd_o, cmd_oe, busy, rst_busy;
  logic [6:0] status, resp_idx;
  logic [31:0] resp0, resp1, resp2, resp3;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine #(.TIMEOUT(64), .RST_CYCLES(RSTC)) i_sd_cmd_engine (
    .clk, .rst_n, .arg_wr, .arg_wdata, .ctl_wr, .ctl_wdata, .cmd_i,
    .cmd_o, .cmd_oe, .busy, .rst_busy, .status,
    .resp0, .resp1, .resp2, .resp3, .resp_idx);

  function automatic logic [6:0] crc_of(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) c = {c[5:0], 1'b0} ^ ((v[i] ^ c[6]) ? 7'h09 : 7'h00);
    return c;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // Issues a command and collects the token; disturb=1 fires a second start mid-token.
  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic need,
                      input logic lng, input logic app, input bit disturb);
    logic [47:0] tok = '0;
    logic [39:0] h;
    int n = 0, guard = 0;
    @(negedge clk); arg_wr = 1; arg_wdata = arg;
    @(negedge clk); arg_wr = 0;
    ctl_wr = 1; ctl_wdata = {2'b01, app, lng, need, idx};
    while (n < 48 && guard < 200) begin
      @(negedge clk); ctl_wr = 0; guard++;
      if (cmd_oe) begin
        tok = {tok[46:0], cmd_o}; n++;
        if (disturb && n == 10) begin ctl_wr = 1; ctl_wdata = {2'b01, 3'b000, ~idx}; end
      end
    end
    ctl_wr = 0;
    h = {2'b01, idx, arg};
    chk(disturb ? "R9 token kept" : "R1 token", tok, {h, crc_of(h, 40), 1'b1});
    @(negedge clk);
    chk("R2 oe released", cmd_oe, 0);
  endtask

  task automatic reply(input logic [135:0] fr, input int nb, input int dly);
    repeat (dly) begin cmd_i = 1; @(negedge clk); end
    for (int i = nb - 1; i >= 0; i--) begin cmd_i = fr[i]; @(negedge clk); end
    cmd_i = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [39:0] h;
    logic [119:0] c120;
    logic [135:0] fr;
    logic [127:0] w;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset status", status, 0);
    chk("R2 reset oe", cmd_oe, 0);
    chk("R8 reset rst_busy", rst_busy, 0);
    chk("R8 reset resp0", resp0, 0);

    for (int k = 0; k < 64; k++) begin
      send(6'(k), (32'(k) * 32'h0102_0304) ^ 32'hA5A5_0000, 0, k[0], 0, 0);
      chk("R3 sent only", status, 7'h40);
    end

    for (int k = 0; k < 6; k++) begin
      logic [5:0] ix = 6'(k * 11 + 2);
      logic [31:0] a = 32'hDEAD_0000 + 32'(k * 7919);
      logic [31:0] p = a ^ 32'h1357_9BDF;
      int d = (k == 5) ? 63 : k * 3;
      send(ix, a, 1, 0, k[0], 0);
      h = {2'b00, ix, p};
      reply({88'h0, h, crc_of({96'h0, h}, 40), 1'b1}, 48, d);
      chk(d == 63 ? "R7 late start accepted" : "R4 status", status, 7'h10);
      chk("R4 resp0", resp0, p);
      chk("R4 resp_idx", resp_idx, {k[0], ix});
    end

    for (int k = 0; k < 3; k++) begin
      c120 = {4{30'(k + 1) * 30'h1234567}};
      send(6'd2, 32'h0, 1, 1, 0, 0);
      fr = {2'b00, 6'h3F, c120, crc_of({16'h0, c120}, 120), 1'b1};
      reply(fr, 136, k * 5);
      w = {c120, crc_of({16'h0, c120}, 120), 1'b0};
      chk("R5 status", status, 7'h10);
      chk("R5 resp0", resp0, w[127:96]);
      chk("R5 resp1", resp1, w[95:64]);
      chk("R5 resp2", resp2, w[63:32]);
      chk("R5 resp3", resp3, w[31:0]);
    end

    send(6'd17, 32'h0BAD_CAFE, 1, 0, 0, 0);
    h = {2'b00, 6'd17, 32'h0BAD_CAFE};
    reply({88'h0, h ^ 40'h1, crc_of({96'h0, h}, 40), 1'b1}, 48, 2);
    chk("R6 short crc fail", status, 7'h01);

    send(6'd9, 32'h0, 1, 1, 0, 0);
    c120 = {4{30'h2AAA5555}};
    fr = {2'b00, 6'h3F, c120, crc_of({16'h0, c120}, 120) ^ 7'h40, 1'b1};
    reply(fr, 136, 1);
    chk("R6 long crc fail", status, 7'h01);

    send(6'd5, 32'h1, 0, 0, 0, 0);
    chk("R10 status cleared at start", status, 7'h40);

    send(6'd8, 32'h5555_AAAA, 1, 0, 0, 0);
    repeat (70) @(negedge clk);
    chk("R7 timeout", status, 7'h04);

    send(6'd33, 32'hCAFE_F00D, 0, 0, 0, 1);
    chk("R9 single completion", status, 7'h40);

    send(6'd12, 32'h1, 1, 0, 1, 0);
    repeat (5) @(negedge clk);
    ctl_wr = 1; ctl_wdata = 11'h400;
    @(negedge clk); ctl_wr = 0;
    hi = 0;
    for (int i = 0; i < 3 * RSTC; i++) begin
      if (rst_busy) hi++;
      @(negedge clk);
    end
    chk("R8 rst_busy length", hi, RSTC);
    chk("R8 cleared status", status, 0);
    chk("R8 cleared resp0", resp0, 0);
    chk("R8 cleared resp_idx", resp_idx, 0);
    chk("R8 idle after reset", busy, 0);

    finish_run();
  end
endmodule